// File: doc/BRIEF.md
# SKP-Compensating Elastic Buffer

This block sits between a receive path clocked by the recovered line clock and the core logic clocked by the local reference. It accepts one 8-bit symbol per write-clock cycle (with a flag marking control characters) and delivers one symbol per read-clock cycle. The small frequency offset between the two clocks is absorbed by editing clock-tolerance ordered sets as they pass: one SKP symbol is dropped when the buffer fills, or one is repeated when it drains.

Each edit is flagged to the consumer with a single-cycle status strobe and a three-bit code that lines up with the edited symbol. Hard overflow and underflow are flagged with their own codes. After either, the buffer re-centres on half full. An overflow moves the read pointer. An underflow stalls the output until the buffer has refilled to half full.

Top module: `elastic_skp_buffer`

## Requirements
- R1: While rst_ni is low, and afterwards until the buffer has first filled to half depth, rd_valid_o and phy_status_o are 0 and rx_status_o is 000.
- R2: When no overflow occurs, the valid output stream with all SKP symbols removed equals the written stream with all SKP symbols removed, in the same order.
- R3: Edits happen only on a SKP symbol (k=1, data 0x1C) inside an ordered set that starts with COM (k=1, data 0xBC). There is at most one edit per ordered set, so a set written with three SKP leaves with two, three or four.
- R4: When the write clock is faster than the read clock, SKP symbols are removed. The fill threshold for removal is half depth plus MARGIN. Each removal is reported with code 010, and that set leaves with one SKP fewer.
- R5: When the write clock is slower than the read clock, SKP symbols are inserted. The fill threshold for insertion is half depth minus MARGIN. Each insertion is reported with code 001, and that set leaves with one SKP more.
- R6: phy_status_o is high for exactly one read cycle per event. For an edit, it is high in the cycle that the edited SKP is on rd_data_o with rd_valid_o high. rx_status_o is 000 whenever phy_status_o is low.
- R7: An overflow is reported with code 101 in a cycle with rd_valid_o low. The read side then jumps back to half full, and valid output resumes in the next cycle.
- R8: An underflow is reported with code 110 in a cycle with rd_valid_o low. Output then stays invalid until the buffer has refilled to half depth, and after that delivery resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered receive clock (write side) |
| rclk_i | input | 1 | Local clock (read side) |
| rst_ni | input | 1 | Asynchronous active-low reset for both sides |
| wr_valid_i | input | 1 | Symbol present on the write side this cycle |
| wr_data_i | input | 8 | Write symbol byte |
| wr_k_i | input | 1 | Write symbol is a control character |
| rd_valid_o | output | 1 | rd_data_o/rd_k_o carry a symbol this cycle |
| rd_data_o | output | 8 | Read symbol byte |
| rd_k_o | output | 1 | Read symbol is a control character |
| phy_status_o | output | 1 | One-cycle event strobe |
| rx_status_o | output | 3 | Event code: 001 insert, 010 remove, 101 overflow, 110 underflow |

## Verification
The bound checker watches every read cycle. It checks that the strobe lasts one cycle, that the code is zero when there is no strobe, and that an edit strobe coincides with a valid SKP on the output. It also checks that no second edit falls between two COM symbols, that error strobes carry no valid data, and that the output stalls after an underflow and resumes after an overflow. Whether edits actually go in the right direction for a given clock ratio can only be shown by the bench, by running the write clock faster, slower and at the same rate as the read clock. The same holds for lossless delivery of the data stream and for SKP counts of two or four per set, which the bench checks against a reference queue.

// File: rtl/eb_pkg.sv
package eb_pkg;
  localparam logic [7:0] COM_BYTE = 8'hBC;
  localparam logic [7:0] SKP_BYTE = 8'h1C;

  typedef enum logic [2:0] {
    STS_OK  = 3'b000,
    STS_ADD = 3'b001,
    STS_REM = 3'b010,
    STS_OVF = 3'b101,
    STS_UNF = 3'b110
  } rx_sts_e;

  typedef struct packed {
    logic       k;
    logic [7:0] d;
  } sym_t;

  function automatic logic is_skp(sym_t s);
    return s.k && (s.d == SKP_BYTE);
  endfunction

  function automatic logic is_com(sym_t s);
    return s.k && (s.d == COM_BYTE);
  endfunction
endpackage

// File: rtl/eb_mem.sv
module eb_mem
  import eb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  sym_t              wsym_i,
  input  logic [ADDR_W-1:0] raddr0_i,
  input  logic [ADDR_W-1:0] raddr1_i,
  output sym_t              rsym0_o,
  output sym_t              rsym1_o
);
  localparam int DEPTH = 1 << ADDR_W;

  sym_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wsym_i;
  end

  // two read ports: current symbol and look-ahead for SKP removal
  assign rsym0_o = mem_q[raddr0_i];
  assign rsym1_o = mem_q[raddr1_i];
endmodule

// File: rtl/eb_wptr.sv
module eb_wptr #(
  parameter int PTR_W = 6
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [PTR_W-1:0] bin_o,
  output logic [PTR_W-1:0] gray_o
);
  logic [PTR_W-1:0] bin_d;

  assign bin_d = bin_o + PTR_W'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o  <= '0;
      gray_o <= '0;
    end else if (inc_i) begin
      bin_o  <= bin_d;
      gray_o <= bin_d ^ (bin_d >> 1);
    end
  end
endmodule

// File: rtl/eb_sync.sv
module eb_sync #(
  parameter int PTR_W  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] gray_i,
  output logic [PTR_W-1:0] bin_o
);
  logic [PTR_W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= gray_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    bin_o[PTR_W-1] = stg_q[STAGES-1][PTR_W-1];
    for (int i = PTR_W-2; i >= 0; i--) begin
      bin_o[i] = bin_o[i+1] ^ stg_q[STAGES-1][i];
    end
  end
endmodule

// File: rtl/eb_rd_ctrl.sv
module eb_rd_ctrl
  import eb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int MARGIN = 4
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W:0]   wbin_i,
  input  sym_t              rsym0_i,
  input  sym_t              rsym1_i,
  output logic [ADDR_W-1:0] raddr0_o,
  output logic [ADDR_W-1:0] raddr1_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_k_o,
  output logic              phy_status_o,
  output logic [2:0]        rx_status_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [PTR_W-1:0] HALF_L = PTR_W'(HALF);
  localparam logic [PTR_W-1:0] HI_L   = PTR_W'(HALF + MARGIN);
  localparam logic [PTR_W-1:0] LO_L   = PTR_W'(HALF - MARGIN);
  localparam logic [PTR_W-1:0] OVF_L  = PTR_W'(DEPTH - 2);

  logic [PTR_W-1:0] rptr_q, fill;
  logic             run_q, in_os_q, edited_q;
  rx_sts_e          sts_q;
  logic             edit_ok, do_rem, do_add;

  assign fill     = wbin_i - rptr_q;
  assign raddr0_o = rptr_q[ADDR_W-1:0];
  assign raddr1_o = raddr0_o + ADDR_W'(1);

  assign edit_ok = in_os_q && !edited_q && is_skp(rsym0_i);
  assign do_rem  = edit_ok && (fill > HI_L) && is_skp(rsym1_i);
  assign do_add  = edit_ok && (fill < LO_L);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q       <= '0;
      run_q        <= 1'b0;
      in_os_q      <= 1'b0;
      edited_q     <= 1'b0;
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      rd_k_o       <= 1'b0;
      phy_status_o <= 1'b0;
      sts_q        <= STS_OK;
    end else begin
      rd_valid_o   <= 1'b0;
      phy_status_o <= 1'b0;
      sts_q        <= STS_OK;
      if (!run_q) begin
        // prime to half full before delivering
        if (fill >= HALF_L) run_q <= 1'b1;
        in_os_q <= 1'b0;
      end else if (fill == '0) begin
        phy_status_o <= 1'b1;
        sts_q        <= STS_UNF;
        run_q        <= 1'b0;
        in_os_q      <= 1'b0;
      end else if (fill >= OVF_L) begin
        phy_status_o <= 1'b1;
        sts_q        <= STS_OVF;
        rptr_q       <= wbin_i - HALF_L;
        in_os_q      <= 1'b0;
      end else begin
        rd_valid_o <= 1'b1;
        rd_data_o  <= rsym0_i.d;
        rd_k_o     <= rsym0_i.k;
        if (do_rem) begin
          rptr_q       <= rptr_q + PTR_W'(2);
          phy_status_o <= 1'b1;
          sts_q        <= STS_REM;
          edited_q     <= 1'b1;
        end else if (do_add) begin
          phy_status_o <= 1'b1;  // pointer holds: SKP is sent twice
          sts_q        <= STS_ADD;
          edited_q     <= 1'b1;
        end else begin
          rptr_q <= rptr_q + PTR_W'(1);
        end
        if (is_com(rsym0_i)) begin
          in_os_q  <= 1'b1;
          edited_q <= 1'b0;
        end else if (!is_skp(rsym0_i)) begin
          in_os_q <= 1'b0;
        end
      end
    end
  end

  assign rx_status_o = sts_q;
endmodule

// File: rtl/elastic_skp_buffer.sv
module elastic_skp_buffer
  import eb_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int MARGIN      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       wclk_i,
  input  logic       rclk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_k_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       rd_k_o,
  output logic       phy_status_o,
  output logic [2:0] rx_status_o
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0]  wbin, wgray, wbin_rd;
  logic [ADDR_W-1:0] raddr0, raddr1;
  sym_t              wsym, rsym0, rsym1;

  assign wsym = '{k: wr_k_i, d: wr_data_i};

  eb_wptr #(.PTR_W(PTR_W)) u_wptr (
    .wclk_i (wclk_i),
    .rst_ni (rst_ni),
    .inc_i  (wr_valid_i),
    .bin_o  (wbin),
    .gray_o (wgray)
  );

  eb_mem #(.ADDR_W(ADDR_W)) u_mem (
    .wclk_i   (wclk_i),
    .we_i     (wr_valid_i),
    .waddr_i  (wbin[ADDR_W-1:0]),
    .wsym_i   (wsym),
    .raddr0_i (raddr0),
    .raddr1_i (raddr1),
    .rsym0_o  (rsym0),
    .rsym1_o  (rsym1)
  );

  eb_sync #(.PTR_W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .gray_i (wgray),
    .bin_o  (wbin_rd)
  );

  eb_rd_ctrl #(.ADDR_W(ADDR_W), .MARGIN(MARGIN)) u_rd (
    .rclk_i       (rclk_i),
    .rst_ni       (rst_ni),
    .wbin_i       (wbin_rd),
    .rsym0_i      (rsym0),
    .rsym1_i      (rsym1),
    .raddr0_o     (raddr0),
    .raddr1_o     (raddr1),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .rd_k_o       (rd_k_o),
    .phy_status_o (phy_status_o),
    .rx_status_o  (rx_status_o)
  );
endmodule

// File: rtl/elastic_skp_buffer_chk.sv
module elastic_skp_buffer_chk
  import eb_pkg::*;
(
  input logic       rclk_i,
  input logic       rst_ni,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       rd_k_o,
  input logic       phy_status_o,
  input logic [2:0] rx_status_o
);
  logic is_edit, is_ovf, is_unf, out_com, edit_seen_q;

  assign is_edit = phy_status_o && (rx_status_o == 3'b001 || rx_status_o == 3'b010);
  assign is_ovf  = phy_status_o && (rx_status_o == 3'b101);
  assign is_unf  = phy_status_o && (rx_status_o == 3'b110);
  assign out_com = rd_valid_o && rd_k_o && (rd_data_o == COM_BYTE);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) edit_seen_q <= 1'b0;
    else if (out_com) edit_seen_q <= 1'b0;
    else if (is_edit) edit_seen_q <= 1'b1;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    phy_status_o |=> !phy_status_o); // R6
  AST_STS_IDLE_ZERO: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !phy_status_o |-> (rx_status_o == 3'b000)); // R6
  AST_EDIT_ON_SKP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    is_edit |-> (rd_valid_o && rd_k_o && rd_data_o == SKP_BYTE)); // R3
  AST_ONE_EDIT_PER_SET: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    is_edit |-> !edit_seen_q); // R3
  AST_OVF_NO_VALID: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    is_ovf |-> !rd_valid_o); // R7
  AST_OVF_RESUME: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    is_ovf |=> rd_valid_o); // R7
  AST_UNF_HALT: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    is_unf |-> !rd_valid_o ##1 !rd_valid_o); // R8
endmodule

bind elastic_skp_buffer elastic_skp_buffer_chk u_chk (
  .rclk_i       (rclk_i),
  .rst_ni       (rst_ni),
  .rd_valid_o   (rd_valid_o),
  .rd_data_o    (rd_data_o),
  .rd_k_o       (rd_k_o),
  .phy_status_o (phy_status_o),
  .rx_status_o  (rx_status_o)
);

// File: tb/elastic_skp_buffer_bench.sv
`timescale 1ps/1ps
module elastic_skp_buffer_bench;
  localparam int CLK_PERIOD = 4000;
  localparam logic [8:0] COM9 = 9'h1BC;
  localparam logic [8:0] SKP9 = 9'h11C;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_k = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_k, phy_status;
  logic [7:0] rd_data;
  logic [2:0] rx_status;

  int  w_half = CLK_PERIOD / 2;
  bit  wr_on = 0, skp_on = 1, integ = 1;
  int  checks = 0, errors = 0;
  int  add_cnt, rem_cnt, ovf_cnt, unf_cnt, valid_cnt, compared;
  int  skp_run, os_pos = 0, gap = 5;
  bit  in_set, set_add, set_rem, set_edit, after_unf, after_ovf;
  logic [8:0] ref_q [$];

  elastic_skp_buffer u_elastic_skp_buffer (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_n),
    .wr_valid_i (wr_valid), .wr_data_i (wr_data), .wr_k_i (wr_k),
    .rd_valid_o (rd_valid), .rd_data_o (rd_data), .rd_k_o (rd_k),
    .phy_status_o (phy_status), .rx_status_o (rx_status)
  );

  initial forever #(CLK_PERIOD/2) rclk = ~rclk;
  initial begin
    #700;
    forever #(w_half) wclk = ~wclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stream generator: random data with COM + 3 SKP sets every 8..24 symbols
  always @(negedge wclk) begin
    logic [8:0] s;
    if (!rst_n || !wr_on) begin
      wr_valid <= 1'b0;
    end else begin
      if (os_pos > 0) begin
        s = SKP9;
        os_pos--;
      end else if (skp_on && gap == 0) begin
        s = COM9;
        os_pos = 3;
        gap = 8 + int'($urandom % 17);
      end else begin
        s = {1'b0, 8'($urandom)};
        if (gap > 0) gap--;
      end
      if (s != SKP9) ref_q.push_back(s);
      wr_valid <= 1'b1;
      wr_k     <= s[8];
      wr_data  <= s[7:0];
    end
  end

  // output monitor
  always @(negedge rclk) begin
    logic [8:0] o, e;
    if (!rst_n) begin
      chk(!rd_valid && !phy_status && rx_status == 3'b000, "R1", "outputs in reset",
          {rd_valid, phy_status, rx_status}, 0);
    end else begin
      o = {rd_k, rd_data};
      if (after_unf) begin
        chk(!rd_valid, "R8", "valid right after underflow", rd_valid, 0);
        after_unf = 0;
      end
      if (after_ovf) begin
        chk(rd_valid, "R7", "resume after overflow", rd_valid, 1);
        after_ovf = 0;
      end
      if (phy_status) begin
        case (rx_status)
          3'b001, 3'b010: begin
            if (rx_status == 3'b001) add_cnt++; else rem_cnt++;
            chk(rd_valid && o == SKP9, "R6", "edit strobe not on SKP", o, SKP9);
            if (integ) begin
              chk(in_set && !set_edit, "R3", "edit outside set or repeated",
                  {in_set, set_edit}, 2);
              set_edit = 1;
              if (rx_status == 3'b001) set_add = 1; else set_rem = 1;
            end
          end
          3'b101: begin
            ovf_cnt++;
            chk(!rd_valid, "R7", "valid on overflow strobe", rd_valid, 0);
            after_ovf = 1;
          end
          3'b110: begin
            unf_cnt++;
            chk(!rd_valid, "R8", "valid on underflow strobe", rd_valid, 0);
            after_unf = 1;
          end
          default: chk(0, "R6", "unknown status code", rx_status, 0);
        endcase
      end else begin
        chk(rx_status == 3'b000, "R6", "code without strobe", rx_status, 0);
      end
      if (rd_valid) valid_cnt++;
      if (rd_valid && integ) begin
        if (o == SKP9) begin
          skp_run++;
        end else begin
          if (in_set)
            chk(skp_run == 3 + int'(set_add) - int'(set_rem), "R3", "SKP count in set",
                skp_run, 3 + int'(set_add) - int'(set_rem));
          in_set = 0;
          e = (ref_q.size() > 0) ? ref_q.pop_front() : 9'h1FF;
          compared++;
          chk(o == e, "R2", "symbol order", o, e);
          if (o == COM9) begin
            in_set = 1; skp_run = 0; set_add = 0; set_rem = 0; set_edit = 0;
          end
        end
      end
    end
  end

  task automatic clear_stats();
    add_cnt = 0; rem_cnt = 0; ovf_cnt = 0; unf_cnt = 0; valid_cnt = 0; compared = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (5) @(posedge rclk);
    ref_q.delete();
    in_set = 0; skp_run = 0; set_add = 0; set_rem = 0; set_edit = 0;
    after_unf = 0; after_ovf = 0; os_pos = 0; gap = 5;
    clear_stats();
    @(posedge rclk);
    #(CLK_PERIOD/4) rst_n = 1'b1;
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    wr_on = 1;
    do_reset();
    // R1: no output before the buffer primes to half depth
    for (int i = 0; i < 4; i++) begin
      @(negedge rclk);
      chk(!rd_valid && !phy_status, "R1", "output before priming", rd_valid, 0);
    end

    // equal rates
    repeat (2000) @(posedge rclk);
    chk(ovf_cnt == 0 && unf_cnt == 0, "R2", "errors at equal rate", ovf_cnt + unf_cnt, 0);
    chk(compared > 1000, "R2", "symbols delivered", compared, 1000);

    // write clock 1% fast
    w_half = CLK_PERIOD / 2 - 20;
    do_reset();
    repeat (3000) @(posedge rclk);
    chk(rem_cnt > add_cnt + 3, "R4", "removals dominate", rem_cnt, add_cnt + 4);
    chk(ovf_cnt == 0 && unf_cnt == 0, "R4", "errors while fast", ovf_cnt + unf_cnt, 0);

    // write clock 1% slow
    w_half = CLK_PERIOD / 2 + 20;
    do_reset();
    repeat (3000) @(posedge rclk);
    chk(add_cnt > rem_cnt + 3, "R5", "insertions dominate", add_cnt, rem_cnt + 4);
    chk(ovf_cnt == 0 && unf_cnt == 0, "R5", "errors while slow", ovf_cnt + unf_cnt, 0);

    // underflow: starve the writer
    w_half = CLK_PERIOD / 2;
    do_reset();
    repeat (500) @(posedge rclk);
    wr_on = 0;
    repeat (100) @(posedge rclk);
    valid_cnt = 0;
    repeat (50) @(posedge rclk);
    chk(unf_cnt == 1, "R8", "underflow events", unf_cnt, 1);
    chk(valid_cnt == 0, "R8", "valid while starved", valid_cnt, 0);
    wr_on = 1;
    valid_cnt = 0;
    repeat (300) @(posedge rclk);
    chk(valid_cnt > 200, "R8", "delivery restarts", valid_cnt, 200);

    // overflow: double-rate writer, no SKP sets to edit
    integ = 0; skp_on = 0;
    w_half = CLK_PERIOD / 4;
    do_reset();
    repeat (300) @(posedge rclk);
    chk(ovf_cnt >= 1, "R7", "overflow reported", ovf_cnt, 1);
    chk(unf_cnt == 0, "R7", "no underflow when flooded", unf_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule